// File: doc/BRIEF.md
# Moving-Inversions Memory Self-Test Engine

This block is a built-in self-test engine for an on-chip synchronous single-port SRAM. After a start pulse it runs a march over the whole array. Each pass first writes a pattern to every word. It then walks upward, reading each word, comparing it, and writing back its complement. Finally it walks downward, expecting the complement and restoring the pattern. The data pattern comes from one of four modes:
- solid zeros and ones,
- a walking bit inside each byte, repeated across the word,
- a one-hot word whose bit position moves with both address and pass,
- a pseudo-random word that changes on every pass.

Each mismatch produces an error record with the following fields:
- the mode,
- the pass number,
- the address,
- the expected word,
- the observed word,
- the differing bits.

A record that repeats the previous address and bit pattern is not reported again. Instead it increments a repeat counter. When every pass has finished the engine raises `done`, and `pass` shows whether the run was free of mismatches.

Top module: `mi_march_bist`

## Requirements
- R1: A `start` pulse while the engine is idle or done begins a run. It clears `pass`, drops `done` and restarts the error history. `done` stays high from the end of the run until the next accepted start. `pass` is high only together with `done`, and only if no compare mismatched during that run. A `start` pulse during a run has no effect on it.
- R2: Each pass first writes the pass pattern to every address from 0 up to the last address. It then sweeps upward from address 0. At each address it reads, compares against the pattern, then writes the bitwise complement to that same address, before moving to the next address.
- R3: After the upward sweep, the engine sweeps downward from the last address to address 0. At each address it reads, compares against the complement, and writes the pattern back. At the end of every pass, each word therefore holds that pass's pattern.
- R4: Read data is compared in the cycle after the read cycle. The write to the same address follows in the cycle after the compare. A read and a write never share a cycle.
- R5: Mode code 0 (solid) runs 2 passes: pass 0 uses all zeros and pass 1 uses all ones.
- R6: Mode code 1 (walking byte) runs 20 passes. Every byte lane carries the same byte. For pass p < 10 that byte has only bit (p mod 8) set. For p >= 10 it has only bit ((p-10) mod 8) clear.
- R7: Mode code 2 (rotating) runs DATA_W passes. In pass p, the word at address a has exactly one set bit, at position (p + a) mod DATA_W.
- R8: Mode code 3 (random) runs RAND_PASSES passes. The word for pass k is the seed with the step applied k+1 times. A seed of zero is replaced by 1. The step is x ^= x<<13, then x ^= x>>17, then x ^= x<<5, all on 32 bits.
- R9: A reported mismatch raises `err_valid` for one cycle. Alongside it the engine presents the mode, the pass index, the address, the expected word, the observed word, and `err_bits` equal to expected XOR observed.
- R10: A mismatch with the same address and the same `err_bits` as the last report in the run produces no new report. It increments `err_repeat` instead, saturating at its maximum. A new report sets `err_repeat` to 1.
- R11: A mismatch found by the very last compare of a run is still reported, and `pass` is low when `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous-domain active-low reset |
| start | input | 1 | Begin a run (accepted when idle or done) |
| mode | input | 2 | Pattern mode code, sampled at start |
| seed | input | DATA_W | Random-mode seed, sampled at start |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after `mem_re` |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with no mismatch |
| err_valid | output | 1 | New error record present |
| err_mode | output | 2 | Mode of the reported error |
| err_pass | output | PASS_W | Pass index of the reported error |
| err_addr | output | ADDR_W | Failing address |
| err_expected | output | DATA_W | Expected word |
| err_observed | output | DATA_W | Observed word |
| err_bits | output | DATA_W | Expected XOR observed |
| err_repeat | output | CNT_W | Consecutive occurrences of the last report |

## Verification
Two events can coincide at the very end of a run: a mismatch on the last downward compare, and the sequencer's step into the done state. The bench provokes this by corrupting only the final read of a solid-mode run. It then requires a report for address 0 in pass 1, and requires `pass` to be low on the first cycle `done` is seen. A second collision happens inside the filter, where a new mismatch must be either reported or counted as a repeat of the last report. This is driven with two stuck bits whose failures alternate (address 9, then 2, then 2 again, then 9). The bench judges it by the exact sequence of three reports and by the final repeat count.

// File: rtl/mi_pkg.sv
// Shared types and the pseudo-random step for the moving-inversions self-test.
package mi_pkg;

    typedef enum logic [1:0] {
        PAT_SOLID  = 2'd0,
        PAT_WALK   = 2'd1,
        PAT_ROTATE = 2'd2,
        PAT_RANDOM = 2'd3
    } pat_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_READ,
        ST_CMP,
        ST_WRITE,
        ST_PASS_END,
        ST_DONE
    } march_st_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } sweep_dir_e;

    // One 32-bit xorshift step: shift-xor left 13, right 17, left 5.
    function automatic logic [31:0] xorshift32(input logic [31:0] x);
        logic [31:0] t;
        t = x ^ (x << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

endpackage

// File: rtl/mi_rand_seq.sv
// Per-pass random word source.
// Loads from the seed when a run starts and steps once at each pass end.
// Assumes the random word is 32 bits wide; other widths are cast from it.
module mi_rand_seq #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [DATA_W-1:0] seed,
    output logic [DATA_W-1:0] word
);
    logic [31:0] state_q;
    logic [31:0] seed32;

    assign seed32 = 32'(seed);

    // Holds the current pass word; a zero seed is replaced by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= 32'd1;
        end else if (load) begin
            state_q <= mi_pkg::xorshift32((seed32 == 32'd0) ? 32'd1 : seed32);
        end else if (advance) begin
            state_q <= mi_pkg::xorshift32(state_q);
        end
    end

    assign word = DATA_W'(state_q);

endmodule

// File: rtl/mi_pattern_gen.sv
// Combinational pattern source: gives the base word for a mode, pass and address.
// Assumes DATA_W is a multiple of 8 and PASS_W is at least 3.
module mi_pattern_gen #(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int PASS_W      = 6,
    parameter int WALK_PASSES = 20
) (
    input  mi_pkg::pat_mode_e   mode,
    input  logic [PASS_W-1:0]   pass_idx,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   rand_word,
    output logic [DATA_W-1:0]   pattern
);
    localparam int LANES     = DATA_W / 8;
    localparam int WALK_HALF = WALK_PASSES / 2;
    localparam int POS_W     = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [7:0]        walk_byte;
    logic [DATA_W-1:0] walk_word;
    logic [DATA_W-1:0] rot_word;
    logic [POS_W-1:0]  rot_pos;

    // Walking byte: a lone one in the first half of the passes, a lone zero after.
    always_comb begin
        if (int'(pass_idx) < WALK_HALF) begin
            walk_byte = 8'd1 << pass_idx[2:0];
        end else begin
            walk_byte = ~(8'd1 << 3'(int'(pass_idx) - WALK_HALF));
        end
    end

    // Replicate the walking byte into every lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign walk_word[g*8 +: 8] = walk_byte;
    end

    // Rotating one-hot: the position advances with both address and pass.
    always_comb begin
        rot_pos  = POS_W'((int'(pass_idx) + int'(addr)) % DATA_W);
        rot_word = {{(DATA_W-1){1'b0}}, 1'b1} << rot_pos;
    end

    // Mode select.
    always_comb begin
        unique case (mode)
            mi_pkg::PAT_SOLID:  pattern = pass_idx[0] ? '1 : '0;
            mi_pkg::PAT_WALK:   pattern = walk_word;
            mi_pkg::PAT_ROTATE: pattern = rot_word;
            default:            pattern = rand_word;
        endcase
    end

endmodule

// File: rtl/mi_error_filter.sv
// Mismatch detector and report filter.
// Reports a mismatch only when its address or bit pattern differs from the
// last report of the run; otherwise it counts the repeat.
// Assumes chk_valid marks the cycle where read data is aligned with the expected word.
module mi_error_filter #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int PASS_W = 6,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              chk_valid,
    input  logic [1:0]        chk_mode,
    input  logic [PASS_W-1:0] chk_pass,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [DATA_W-1:0] chk_expected,
    input  logic [DATA_W-1:0] chk_observed,
    output logic              err_valid,
    output logic [1:0]        err_mode,
    output logic [PASS_W-1:0] err_pass,
    output logic [ADDR_W-1:0] err_addr,
    output logic [DATA_W-1:0] err_expected,
    output logic [DATA_W-1:0] err_observed,
    output logic [DATA_W-1:0] err_bits,
    output logic [CNT_W-1:0]  err_repeat,
    output logic              fail_seen
);
    logic [DATA_W-1:0] diff;
    logic              have_last_q;
    logic              mismatch;
    logic              same_as_last;

    assign diff         = chk_expected ^ chk_observed;
    assign mismatch     = chk_valid && (diff != '0);
    assign same_as_last = have_last_q && (chk_addr == err_addr) && (diff == err_bits);

    // Records a new report or counts a repeat; clears history on a new run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid    <= 1'b0;
            err_mode     <= '0;
            err_pass     <= '0;
            err_addr     <= '0;
            err_expected <= '0;
            err_observed <= '0;
            err_bits     <= '0;
            err_repeat   <= '0;
            have_last_q  <= 1'b0;
            fail_seen    <= 1'b0;
        end else begin
            err_valid <= 1'b0;
            if (clear) begin
                have_last_q <= 1'b0;
                err_repeat  <= '0;
                fail_seen   <= 1'b0;
            end else if (mismatch) begin
                fail_seen <= 1'b1;
                if (same_as_last) begin
                    if (err_repeat != '1) begin
                        err_repeat <= err_repeat + 1'b1;
                    end
                end else begin
                    err_valid    <= 1'b1;
                    err_mode     <= chk_mode;
                    err_pass     <= chk_pass;
                    err_addr     <= chk_addr;
                    err_expected <= chk_expected;
                    err_observed <= chk_observed;
                    err_bits     <= diff;
                    err_repeat   <= CNT_W'(1);
                    have_last_q  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mi_march_ctrl.sv
// March sequencer: fill, ascending check-and-invert, descending check-and-restore,
// repeated for every pass of the selected mode.
// Assumes a synchronous memory that returns read data one cycle after the read.
module mi_march_ctrl #(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int PASS_W      = 6,
    parameter int WALK_PASSES = 20,
    parameter int RAND_PASSES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode_in,
    input  logic [DATA_W-1:0] pattern,
    output mi_pkg::pat_mode_e mode_q,
    output logic [PASS_W-1:0] pass_idx,
    output logic [ADDR_W-1:0] addr,
    output logic              start_ok,
    output logic              pass_adv,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              chk_valid,
    output logic [DATA_W-1:0] chk_expected,
    output logic              done
);
    import mi_pkg::*;

    localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

    march_st_e         state_q;
    sweep_dir_e        dir_q;
    logic [PASS_W-1:0] last_pass;

    // Final pass index for the latched mode.
    always_comb begin
        unique case (mode_q)
            PAT_SOLID:  last_pass = PASS_W'(1);
            PAT_WALK:   last_pass = PASS_W'(WALK_PASSES - 1);
            PAT_ROTATE: last_pass = PASS_W'(DATA_W - 1);
            default:    last_pass = PASS_W'(RAND_PASSES - 1);
        endcase
    end

    assign start_ok = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));

    // State, address, direction and pass bookkeeping of the march.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            dir_q    <= DIR_UP;
            addr     <= '0;
            pass_idx <= '0;
            mode_q   <= PAT_SOLID;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        mode_q   <= pat_mode_e'(mode_in);
                        pass_idx <= '0;
                        addr     <= '0;
                        dir_q    <= DIR_UP;
                        state_q  <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (addr == ADDR_LAST) begin
                        addr    <= '0;
                        dir_q   <= DIR_UP;
                        state_q <= ST_READ;
                    end else begin
                        addr <= addr + 1'b1;
                    end
                end
                ST_READ:  state_q <= ST_CMP;
                ST_CMP:   state_q <= ST_WRITE;
                ST_WRITE: begin
                    if (dir_q == DIR_UP) begin
                        if (addr == ADDR_LAST) begin
                            dir_q <= DIR_DOWN;
                        end else begin
                            addr <= addr + 1'b1;
                        end
                        state_q <= ST_READ;
                    end else if (addr == '0) begin
                        state_q <= ST_PASS_END;
                    end else begin
                        addr    <= addr - 1'b1;
                        state_q <= ST_READ;
                    end
                end
                ST_PASS_END: begin
                    if (pass_idx == last_pass) begin
                        state_q <= ST_DONE;
                    end else begin
                        pass_idx <= pass_idx + 1'b1;
                        addr     <= '0;
                        dir_q    <= DIR_UP;
                        state_q  <= ST_FILL;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory strobes and data, compare strobe and expected word, by state.
    always_comb begin
        mem_we       = (state_q == ST_FILL) || (state_q == ST_WRITE);
        mem_re       = (state_q == ST_READ);
        chk_valid    = (state_q == ST_CMP);
        pass_adv     = (state_q == ST_PASS_END);
        done         = (state_q == ST_DONE);
        chk_expected = (dir_q == DIR_UP) ? pattern : ~pattern;
        if ((state_q == ST_WRITE) && (dir_q == DIR_UP)) begin
            mem_wdata = ~pattern;
        end else begin
            mem_wdata = pattern;
        end
    end

endmodule

// File: rtl/mi_march_bist.sv
// Moving-inversions self-test engine top: ties the sequencer, pattern source,
// random source and error filter to a single-port synchronous memory port.
// Assumes ADDR_W addresses a fully populated array of 2**ADDR_W words.
module mi_march_bist #(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int PASS_W      = 6,
    parameter int CNT_W       = 8,
    parameter int WALK_PASSES = 20,
    parameter int RAND_PASSES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] seed,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              pass,
    output logic              err_valid,
    output logic [1:0]        err_mode,
    output logic [PASS_W-1:0] err_pass,
    output logic [ADDR_W-1:0] err_addr,
    output logic [DATA_W-1:0] err_expected,
    output logic [DATA_W-1:0] err_observed,
    output logic [DATA_W-1:0] err_bits,
    output logic [CNT_W-1:0]  err_repeat
);
    mi_pkg::pat_mode_e mode_q;
    logic [PASS_W-1:0] pass_idx;
    logic [ADDR_W-1:0] addr;
    logic              start_ok;
    logic              pass_adv;
    logic              chk_valid;
    logic [DATA_W-1:0] chk_expected;
    logic [DATA_W-1:0] pattern;
    logic [DATA_W-1:0] rand_word;
    logic              fail_seen;

    mi_march_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PASS_W(PASS_W),
        .WALK_PASSES(WALK_PASSES), .RAND_PASSES(RAND_PASSES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode),
        .pattern(pattern), .mode_q(mode_q), .pass_idx(pass_idx), .addr(addr),
        .start_ok(start_ok), .pass_adv(pass_adv), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .chk_valid(chk_valid), .chk_expected(chk_expected),
        .done(done)
    );

    mi_pattern_gen #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PASS_W(PASS_W), .WALK_PASSES(WALK_PASSES)
    ) u_pat (
        .mode(mode_q), .pass_idx(pass_idx), .addr(addr),
        .rand_word(rand_word), .pattern(pattern)
    );

    mi_rand_seq #(.DATA_W(DATA_W)) u_rand (
        .clk(clk), .rst_n(rst_n), .load(start_ok), .advance(pass_adv),
        .seed(seed), .word(rand_word)
    );

    mi_error_filter #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PASS_W(PASS_W), .CNT_W(CNT_W)
    ) u_filt (
        .clk(clk), .rst_n(rst_n), .clear(start_ok), .chk_valid(chk_valid),
        .chk_mode(mode_q), .chk_pass(pass_idx), .chk_addr(addr),
        .chk_expected(chk_expected), .chk_observed(mem_rdata),
        .err_valid(err_valid), .err_mode(err_mode), .err_pass(err_pass),
        .err_addr(err_addr), .err_expected(err_expected), .err_observed(err_observed),
        .err_bits(err_bits), .err_repeat(err_repeat), .fail_seen(fail_seen)
    );

    assign mem_addr = addr;
    assign pass     = done && !fail_seen;

endmodule

// File: rtl/mi_march_bist_chk.sv
// Port-level protocol checker for mi_march_bist, attached by bind.
module mi_march_bist_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_re,
    input logic              done,
    input logic              pass,
    input logic              err_valid,
    input logic [DATA_W-1:0] err_expected,
    input logic [DATA_W-1:0] err_observed,
    input logic [DATA_W-1:0] err_bits,
    input logic [CNT_W-1:0]  err_repeat
);
    logic saw_err_q;

    // Tracks whether the current run has reported any error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saw_err_q <= 1'b0;
        end else if (start && done) begin
            saw_err_q <= 1'b0;
        end else if (err_valid) begin
            saw_err_q <= 1'b1;
        end
    end

    assert_no_rw_same_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_idle_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (!mem_we && !mem_re));

    assert_write_back_same_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> ##1 (mem_we && (mem_addr == $past(mem_addr, 2))));

    assert_err_bits_xor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> ((err_bits == (err_expected ^ err_observed)) && (err_bits != '0)));

    assert_new_report_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (err_repeat == CNT_W'(1)));

    assert_pass_means_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> !saw_err_q);

    assert_done_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass)));

endmodule

bind mi_march_bist mi_march_bist_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .done(done), .pass(pass),
    .err_valid(err_valid), .err_expected(err_expected), .err_observed(err_observed),
    .err_bits(err_bits), .err_repeat(err_repeat)
);

// File: tb/mi_march_bist_tb.sv
// Directed bench: a memory model with fault injection, one task per scenario.
module mi_march_bist_tb;
    localparam int CLK_PERIOD  = 10;
    localparam int ADDR_W      = 4;
    localparam int DATA_W      = 32;
    localparam int DEPTH       = 16;
    localparam int PASS_W      = 6;
    localparam int CNT_W       = 8;
    localparam int RAND_PASSES = 4;
    localparam int LOG_MAX     = 256;
    localparam int ERR_MAX     = 8;
    localparam int PASS_OPS    = 3 * DEPTH;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        mode = 2'd0;
    logic [DATA_W-1:0] seed = '0;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_we;
    logic              mem_re;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              done;
    logic              pass;
    logic              err_valid;
    logic [1:0]        err_mode;
    logic [PASS_W-1:0] err_pass;
    logic [ADDR_W-1:0] err_addr;
    logic [DATA_W-1:0] err_expected;
    logic [DATA_W-1:0] err_observed;
    logic [DATA_W-1:0] err_bits;
    logic [CNT_W-1:0]  err_repeat;

    int total = 0;
    int bad   = 0;

    // Memory model and fault controls
    logic [DATA_W-1:0] mem_model [DEPTH];
    logic [DATA_W-1:0] sa0_mask  [DEPTH];
    logic [DATA_W-1:0] sa1_mask  [DEPTH];
    logic [DATA_W-1:0] flip_mask = '0;
    int                flip_read_no = -1;
    int                read_no = 0;

    // Monitor logs
    int                wr_cnt = 0, rd_cnt = 0, ev_n = 0, ev_base = 0, err_n = 0, err_base = 0;
    logic              ev_wr   [LOG_MAX];
    logic [ADDR_W-1:0] ev_addr [LOG_MAX];
    logic [DATA_W-1:0] ev_data [LOG_MAX];
    logic [ADDR_W-1:0] rep_addr [ERR_MAX];
    logic [DATA_W-1:0] rep_exp  [ERR_MAX];
    logic [DATA_W-1:0] rep_obs  [ERR_MAX];
    logic [DATA_W-1:0] rep_bits [ERR_MAX];
    logic [PASS_W-1:0] rep_pass [ERR_MAX];
    logic [1:0]        rep_mode [ERR_MAX];
    logic              pass_at_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mi_march_bist #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PASS_W(PASS_W), .CNT_W(CNT_W),
        .WALK_PASSES(20), .RAND_PASSES(RAND_PASSES)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .seed(seed),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .done(done), .pass(pass), .err_valid(err_valid),
        .err_mode(err_mode), .err_pass(err_pass), .err_addr(err_addr),
        .err_expected(err_expected), .err_observed(err_observed),
        .err_bits(err_bits), .err_repeat(err_repeat)
    );

    // Synchronous single-port memory with stuck-at and one-shot read flips.
    always @(posedge clk) begin
        logic [DATA_W-1:0] rd;
        if (mem_re) begin
            read_no = read_no + 1;
            rd = (mem_model[mem_addr] & ~sa0_mask[mem_addr]) | sa1_mask[mem_addr];
            if (read_no == flip_read_no) rd = rd ^ flip_mask;
            mem_rdata <= rd;
        end
        if (mem_we) mem_model[mem_addr] <= mem_wdata;
    end

    // Port monitor, sampling away from the active edge.
    always @(negedge clk) begin
        if (mem_we || mem_re) begin
            if (ev_n - ev_base < LOG_MAX) begin
                ev_wr[ev_n - ev_base]   = mem_we;
                ev_addr[ev_n - ev_base] = mem_addr;
                ev_data[ev_n - ev_base] = mem_wdata;
            end
            ev_n = ev_n + 1;
        end
        if (mem_we) wr_cnt = wr_cnt + 1;
        if (mem_re) rd_cnt = rd_cnt + 1;
        if (err_valid) begin
            if (err_n - err_base < ERR_MAX) begin
                rep_addr[err_n - err_base] = err_addr;
                rep_exp[err_n - err_base]  = err_expected;
                rep_obs[err_n - err_base]  = err_observed;
                rep_bits[err_n - err_base] = err_bits;
                rep_pass[err_n - err_base] = err_pass;
                rep_mode[err_n - err_base] = err_mode;
            end
            err_n = err_n + 1;
        end
    end

    function automatic logic [31:0] xs_step(input logic [31:0] x);
        logic [31:0] t;
        t = x ^ (x << 13);
        t = t ^ (t >> 17);
        return t ^ (t << 5);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_faults();
        for (int i = 0; i < DEPTH; i++) begin
            sa0_mask[i] = '0;
            sa1_mask[i] = '0;
        end
        flip_read_no = -1;
        flip_mask    = '0;
    endtask

    // Starts one run and waits for done; optionally pokes start mid-run.
    task automatic run_march(input logic [1:0] m, input logic [DATA_W-1:0] s, input bit poke);
        @(negedge clk);
        wr_cnt = 0; rd_cnt = 0; ev_base = ev_n; err_base = err_n;
        mode = m; seed = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20000 && !done; i++) begin
            @(negedge clk);
            start = (poke && i == 100);
        end
        start = 1'b0;
        pass_at_done = pass;
        check(done == 1'b1, "R1 done reached", done, 1);
    endtask

    task automatic t_reset();
        check(done == 1'b0 && pass == 1'b0, "R1 reset done/pass", {done, pass}, 0);
        check(mem_we == 1'b0 && mem_re == 1'b0, "R4 reset strobes", {mem_we, mem_re}, 0);
        check(err_valid == 1'b0, "R9 reset err_valid", err_valid, 0);
    endtask

    task automatic t_solid_clean();
        bit ok;
        clear_faults();
        run_march(2'd0, '0, 1'b0);
        check(pass_at_done == 1'b1, "R1 clean solid pass", pass_at_done, 1);
        check(wr_cnt == 2 * PASS_OPS, "R5 solid write count", wr_cnt, 2 * PASS_OPS);
        check(rd_cnt == 4 * DEPTH, "R5 solid read count", rd_cnt, 4 * DEPTH);
        check(err_n == err_base, "R9 no reports on clean run", err_n - err_base, 0);
        ok = 1;
        for (int a = 0; a < DEPTH; a++)
            if (!ev_wr[a] || ev_addr[a] != ADDR_W'(a) || ev_data[a] != '0) ok = 0;
        check(ok, "R2 fill order and zero data", ok, 1);
        ok = 1;
        for (int a = 0; a < DEPTH; a++) begin
            if (ev_wr[DEPTH + 2*a] || ev_addr[DEPTH + 2*a] != ADDR_W'(a)) ok = 0;
            if (!ev_wr[DEPTH + 2*a + 1] || ev_addr[DEPTH + 2*a + 1] != ADDR_W'(a)
                || ev_data[DEPTH + 2*a + 1] != '1) ok = 0;
        end
        check(ok, "R2 ascending read then complement write", ok, 1);
        ok = 1;
        for (int j = 0; j < DEPTH; j++) begin
            if (ev_wr[3*DEPTH + 2*j] || ev_addr[3*DEPTH + 2*j] != ADDR_W'(DEPTH - 1 - j)) ok = 0;
            if (!ev_wr[3*DEPTH + 2*j + 1] || ev_addr[3*DEPTH + 2*j + 1] != ADDR_W'(DEPTH - 1 - j)
                || ev_data[3*DEPTH + 2*j + 1] != '0) ok = 0;
        end
        check(ok, "R3 descending read then restore write", ok, 1);
        check(ev_data[5*DEPTH] == '1, "R5 second pass fills ones", ev_data[5*DEPTH], '1);
        ok = 1;
        for (int a = 0; a < DEPTH; a++) if (mem_model[a] != '1) ok = 0;
        check(ok, "R3 memory holds last pattern", ok, 1);
    endtask

    task automatic t_walk_with_poke();
        bit ok;
        clear_faults();
        run_march(2'd1, '0, 1'b1);
        check(pass_at_done == 1'b1, "R6 walk clean pass", pass_at_done, 1);
        check(wr_cnt == 20 * PASS_OPS, "R1 start during run ignored", wr_cnt, 20 * PASS_OPS);
        check(ev_data[0] == 32'h01010101, "R6 pass 0 walking one", ev_data[0], 32'h01010101);
        check(ev_data[5*DEPTH] == 32'h02020202, "R6 pass 1 walking one", ev_data[5*DEPTH], 32'h02020202);
        ok = 1;
        for (int a = 0; a < DEPTH; a++) if (mem_model[a] != 32'hFDFDFDFD) ok = 0;
        check(ok, "R6 last pass walking zero", mem_model[0], 32'hFDFDFDFD);
    endtask

    task automatic t_rotate();
        bit ok;
        clear_faults();
        run_march(2'd2, '0, 1'b0);
        check(wr_cnt == DATA_W * PASS_OPS, "R7 rotate pass count", wr_cnt, DATA_W * PASS_OPS);
        ok = 1;
        for (int a = 0; a < DEPTH; a++) begin
            if (ev_data[a] != (DATA_W'(1) << a)) ok = 0;
            if (ev_data[5*DEPTH + a] != (DATA_W'(1) << (a + 1))) ok = 0;
        end
        check(ok, "R7 rotation per address and per pass", ok, 1);
        ok = 1;
        for (int a = 0; a < DEPTH; a++)
            if (mem_model[a] != (DATA_W'(1) << ((DATA_W - 1 + a) % DATA_W))) ok = 0;
        check(ok, "R7 last pass contents", mem_model[1], 1);
    endtask

    task automatic t_random(input logic [31:0] s);
        logic [31:0] v, first;
        bit ok;
        clear_faults();
        run_march(2'd3, s, 1'b0);
        v = (s == 0) ? 32'd1 : s;
        v = xs_step(v);
        first = v;
        check(ev_data[0] == first, "R8 first pass word", ev_data[0], first);
        v = xs_step(v);
        check(ev_data[5*DEPTH] == v && v != first, "R8 word changes per pass", ev_data[5*DEPTH], v);
        v = xs_step(xs_step(v));
        ok = 1;
        for (int a = 0; a < DEPTH; a++) if (mem_model[a] != v) ok = 0;
        check(ok, "R8 last pass contents", mem_model[0], v);
    endtask

    task automatic t_single_stuck();
        clear_faults();
        sa1_mask[5] = 32'h8;
        run_march(2'd0, '0, 1'b0);
        check(pass_at_done == 1'b0, "R1 fault clears pass", pass_at_done, 0);
        check(err_n - err_base == 1, "R10 one report for repeated fault", err_n - err_base, 1);
        check(rep_addr[0] == 5 && rep_exp[0] == 0 && rep_obs[0] == 32'h8 && rep_bits[0] == 32'h8
              && rep_pass[0] == 0 && rep_mode[0] == 0,
              "R9 record fields", {rep_addr[0], rep_obs[0]}, {4'd5, 32'h8});
        check(err_repeat == 2, "R10 repeat count", err_repeat, 2);
    endtask

    task automatic t_two_faults();
        clear_faults();
        sa0_mask[2] = 32'h1;
        sa1_mask[9] = 32'h80000000;
        run_march(2'd0, '0, 1'b0);
        check(err_n - err_base == 3, "R10 alternating faults report count", err_n - err_base, 3);
        check(rep_addr[0] == 9 && rep_addr[1] == 2 && rep_addr[2] == 9,
              "R10 report order", {rep_addr[0], rep_addr[1], rep_addr[2]}, 12'h929);
        check(rep_bits[1] == 32'h1 && rep_exp[1] == '1 && rep_pass[2] == 1,
              "R9 second record bits", rep_bits[1], 1);
        check(err_repeat == 1, "R10 count restarts on new report", err_repeat, 1);
    endtask

    task automatic t_last_compare();
        clear_faults();
        flip_mask    = 32'h10;
        flip_read_no = read_no + 4 * DEPTH;
        run_march(2'd0, '0, 1'b0);
        check(pass_at_done == 1'b0, "R11 pass low when done rises", pass_at_done, 0);
        check(err_n - err_base == 1 && rep_addr[0] == 0 && rep_pass[0] == 1 && rep_bits[0] == 32'h10,
              "R11 last compare reported", {rep_addr[0], rep_bits[0]}, 32'h10);
    endtask

    task automatic t_restart_clean();
        clear_faults();
        run_march(2'd0, '0, 1'b0);
        check(pass_at_done == 1'b1, "R1 restart clears failure", pass_at_done, 1);
        check(err_repeat == 0, "R10 history cleared on start", err_repeat, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_faults();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_solid_clean();
        t_walk_with_poke();
        t_rotate();
        t_random(32'h12345678);
        t_random(32'h0);
        t_single_stuck();
        t_two_faults();
        t_last_compare();
        t_restart_clean();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule